// File: doc/BRIEF.md
# PCI Configuration Access Controller

This block sits on the host side of a PCI bridge and turns plain processor register accesses into configuration cycles. The processor first loads a packed configuration-address word through a low window of the block's address range. Accesses to the upper window then become configuration reads or writes. Each one is aimed at the bus, device, function and register named by that word.

Bus zero gives a Type 0 cycle for the local devices; any other bus gives a Type 1 cycle. The processor side is big-endian and the configuration space is little-endian, so the block swaps byte lanes in both directions. A write narrower than a dword needs two downstream transactions: the block reads the target dword, merges in the new bytes and writes the result back. A read from a device that is absent returns all ones.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the configuration-address word is zero, so reading it returns 0 and configuration-data accesses are disabled.
- R2: A host access at an offset below 0x200000 reaches the configuration-address word, whatever its size. A write replaces all 32 bits, a read returns all 32 bits, and it completes on the next cycle with no downstream request.
- R3: A host access at offset 0x200000 or above, made while bit 7 of the address word is clear, issues no downstream request and completes on the next cycle. A read returns 0 and a write is dropped.
- R4: When bit 7 is set, the downstream fields are decoded from the address word as follows: bus from bits 15:8, device from bits 23:19, function from bits 18:16, and register from bits 31:24 with bits 1:0 forced to zero. dn_type1 is 1 exactly when the bus field is nonzero.
- R5: A 4-byte write is sent as one downstream write with the bytes reversed: downstream lane 0 (bits 7:0) carries host bits 31:24, and so on up to lane 3, which carries host bits 7:0.
- R6: A 1- or 2-byte write issues a downstream read, then a downstream write of the returned dword with new bytes merged in. A 1-byte write puts host bits 7:0 in lane `offset`. A 2-byte write puts host bits 15:8 in lane `offset` and host bits 7:0 in lane `offset+1`. All other lanes keep their old values.
- R7: If the downstream read of a narrow write reports the device absent, no write-back is issued and the access completes.
- R8: Read data is formatted by size. A 4-byte read returns the dword with its bytes reversed. A 2-byte read returns {lane `offset`, lane `offset+1`} in bits 15:0. A 1-byte read returns lane `offset` in bits 7:0. In both narrow cases the upper bits are zero.
- R9: A configuration read whose response reports the device absent returns 0xFFFFFFFF.
- R10: host_busy is high from the acceptance of a downstream-bound access until it completes. Host requests made while busy are ignored. A downstream request holds dn_valid and its fields stable until dn_ready.
- R11: dn_size carries the host access size (1, 2 or 4) and dn_offset carries host address bits 1:0, on every downstream transaction of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, taken when not busy |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Offset within the bridge window |
| host_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| host_wdata | input | 32 | Host write data, big-endian, right-aligned |
| host_rdata | output | 32 | Read result, valid with host_done |
| host_done | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | Downstream transfer in progress |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Downstream request is a write |
| dn_type1 | output | 1 | Type 1 cycle (bus nonzero) |
| dn_bus | output | 8 | Bus number |
| dn_dev | output | 5 | Device number |
| dn_func | output | 3 | Function number |
| dn_reg | output | 8 | Dword-aligned register offset |
| dn_size | output | 3 | Access size in bytes |
| dn_offset | output | 2 | Byte offset within the dword |
| dn_wdata | output | 32 | Little-endian write dword |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_data | input | 32 | Little-endian read dword |
| dn_present | input | 1 | Target device answered |

## Verification
Two functions can fall into the same stretch of cycles: a host access to the address word, and a configuration transfer still in flight that depends on that word. The bench stalls dn_ready for several cycles and delays the response so the controller stays busy. In that window it presents a write to the address word. The write must be ignored, so reading the word back afterwards must show the old value. The stalled read must still return data formatted from the original decode.

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge #(
  parameter int ADDR_W = 22,
  parameter logic [ADDR_W-1:0] DATA_BASE = 22'h200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [2:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_done,
  output logic              host_busy,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic              dn_type1,
  output logic [7:0]        dn_bus,
  output logic [4:0]        dn_dev,
  output logic [2:0]        dn_func,
  output logic [7:0]        dn_reg,
  output logic [2:0]        dn_size,
  output logic [1:0]        dn_offset,
  output logic [31:0]       dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic [31:0]       dn_rsp_data,
  input  logic              dn_present
);

  typedef enum logic [2:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT} state_t;

  state_t      state;
  logic [31:0] ca_q;
  logic        rmw_q;
  logic [2:0]  size_q;
  logic [1:0]  off_q;
  logic [31:0] hdata_q;
  logic [31:0] wbuf_q;

  logic accept, in_data_win, enabled;
  assign accept      = host_req && (state == S_IDLE);
  assign in_data_win = host_addr >= DATA_BASE;
  assign enabled     = ca_q[7];

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [7:0] lane(input logic [31:0] v, input int idx);
    return v[8*(idx & 3) +: 8];
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] hv,
                                        input logic [2:0] sz, input logic [1:0] off);
    logic [31:0] r;
    int o;
    r = old;
    o = int'(off);
    if (sz == 3'd1) begin
      r[8*o +: 8] = hv[7:0];
    end else if (sz == 3'd2) begin
      r[8*o +: 8] = hv[15:8];
      if (o < 3) r[8*(o+1) +: 8] = hv[7:0];
    end else begin
      r = bswap(hv);
    end
    return r;
  endfunction

  function automatic logic [31:0] format_rd(input logic [31:0] d, input logic [2:0] sz,
                                            input logic [1:0] off);
    int o;
    o = int'(off);
    if (sz == 3'd1)      return {24'h0, lane(d, o)};
    else if (sz == 3'd2) return {16'h0, lane(d, o), lane(d, o + 1)};
    else                 return bswap(d);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ca_q       <= '0;
      rmw_q      <= 1'b0;
      size_q     <= 3'd4;
      off_q      <= 2'd0;
      hdata_q    <= '0;
      wbuf_q     <= '0;
      host_rdata <= '0;
      host_done  <= 1'b0;
    end else begin
      host_done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (!in_data_win) begin
            if (host_wr) ca_q <= host_wdata;
            else         host_rdata <= ca_q;
            host_done <= 1'b1;
          end else if (!enabled) begin
            if (!host_wr) host_rdata <= '0;
            host_done <= 1'b1;
          end else begin
            size_q  <= host_size;
            off_q   <= host_addr[1:0];
            hdata_q <= host_wdata;
            if (!host_wr) begin
              rmw_q <= 1'b0;
              state <= S_RD_REQ;
            end else if (host_size == 3'd4) begin
              wbuf_q <= bswap(host_wdata);
              state  <= S_WR_REQ;
            end else begin
              rmw_q <= 1'b1;
              state <= S_RD_REQ;
            end
          end
        end
        S_RD_REQ: if (dn_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (dn_rsp_valid) begin
          if (!rmw_q) begin
            host_rdata <= dn_present ? format_rd(dn_rsp_data, size_q, off_q) : 32'hFFFF_FFFF;
            host_done  <= 1'b1;
            state      <= S_IDLE;
          end else if (!dn_present) begin
            host_done <= 1'b1;
            state     <= S_IDLE;
          end else begin
            wbuf_q <= merge(dn_rsp_data, hdata_q, size_q, off_q);
            state  <= S_WR_REQ;
          end
        end
        S_WR_REQ: if (dn_ready) state <= S_WR_WAIT;
        S_WR_WAIT: if (dn_rsp_valid) begin
          host_done <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign host_busy = state != S_IDLE;
  assign dn_valid  = (state == S_RD_REQ) || (state == S_WR_REQ);
  assign dn_write  = state == S_WR_REQ;
  assign dn_bus    = ca_q[15:8];
  assign dn_dev    = ca_q[23:19];
  assign dn_func   = ca_q[18:16];
  assign dn_reg    = {ca_q[31:26], 2'b00};
  assign dn_type1  = |ca_q[15:8];
  assign dn_size   = size_q;
  assign dn_offset = off_q;
  assign dn_wdata  = wbuf_q;

  assert_busy_ignores_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy && host_req) |=> $stable(ca_q));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_write) && $stable(dn_wdata) && $stable(dn_reg)));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_data_win && !enabled) |=> (!host_busy && host_done && !dn_valid &&
                                             ($past(host_wr) || host_rdata == 32'h0)));

  assert_absent_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD_WAIT && dn_rsp_valid && !dn_present && !rmw_q) |=>
      (host_done && host_rdata == 32'hFFFF_FFFF));

  assert_absent_no_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD_WAIT && dn_rsp_valid && !dn_present && rmw_q) |=> (!host_busy && !dn_valid));

endmodule

// File: tb/cfg_access_bridge_bench.sv
module cfg_access_bridge_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [21:0] host_addr = '0;
  logic [2:0]  host_size = 3'd4;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_done, host_busy;
  logic        dn_valid, dn_ready, dn_write, dn_type1;
  logic [7:0]  dn_bus, dn_reg;
  logic [4:0]  dn_dev;
  logic [2:0]  dn_func, dn_size;
  logic [1:0]  dn_offset;
  logic [31:0] dn_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic [31:0] dn_rsp_data = '0;
  logic        dn_present = 1'b0;

  cfg_access_bridge u_cfg_access_bridge (
    .clk, .rst_n, .host_req, .host_wr, .host_addr, .host_size, .host_wdata,
    .host_rdata, .host_done, .host_busy, .dn_valid, .dn_ready, .dn_write, .dn_type1,
    .dn_bus, .dn_dev, .dn_func, .dn_reg, .dn_size, .dn_offset, .dn_wdata,
    .dn_rsp_valid, .dn_rsp_data, .dn_present);

  int errors = 0, checks = 0;
  int ready_lag = 0, rsp_lag = 0, wait_cnt = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] store [32];
  logic        pend = 1'b0, p_wr = 1'b0, p_pres = 1'b0;
  logic [4:0]  p_idx = '0;
  logic [31:0] p_wd = '0;
  int          p_cnt = 0;
  logic        l_type1;
  logic [7:0]  l_bus, l_reg;
  logic [4:0]  l_dev;
  logic [2:0]  l_func, l_size;
  logic [1:0]  l_off;
  logic [31:0] l_wd;

  assign dn_ready = dn_valid && (wait_cnt >= ready_lag);

  always @(posedge clk) begin
    dn_rsp_valid <= 1'b0;
    if (dn_valid && !dn_ready) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (dn_valid && dn_ready) begin
      pend <= 1'b1; p_cnt <= rsp_lag; p_wr <= dn_write; p_wd <= dn_wdata;
      p_idx <= dn_reg[6:2]; p_pres <= (dn_dev != 5'd31);
      l_type1 <= dn_type1; l_bus <= dn_bus; l_dev <= dn_dev; l_func <= dn_func;
      l_reg <= dn_reg; l_size <= dn_size; l_off <= dn_offset;
      if (dn_write) begin wr_cnt <= wr_cnt + 1; l_wd <= dn_wdata; end
      else rd_cnt <= rd_cnt + 1;
    end else if (pend) begin
      if (p_cnt == 0) begin
        pend <= 1'b0; dn_rsp_valid <= 1'b1; dn_present <= p_pres;
        dn_rsp_data <= store[p_idx];
        if (p_wr && p_pres) store[p_idx] <= p_wd;
      end else p_cnt <= p_cnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [21:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_done) @(negedge clk);
    rd = host_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk("R1 busy after reset", {31'b0, host_busy}, 32'h0);
    access(1'b0, 22'h000000, 3'd4, 32'h0, r);
    chk("R1 address word after reset", r, 32'h0);
  endtask

  task automatic t_addr_word();
    logic [31:0] r;
    int w0;
    w0 = wr_cnt + rd_cnt;
    access(1'b1, 22'h001000, 3'd1, 32'h1234_5678, r);
    access(1'b0, 22'h1FFFFC, 3'd2, 32'h0, r);
    chk("R2 address word full readback", r, 32'h1234_5678);
    chk("R2 no downstream traffic", wr_cnt + rd_cnt, w0);
  endtask

  task automatic t_disabled();
    logic [31:0] r;
    int w0;
    w0 = wr_cnt + rd_cnt;
    access(1'b1, 22'h000000, 3'd4, 32'h472B_0000, r);
    access(1'b1, 22'h200000, 3'd4, 32'hAAAA_5555, r);
    access(1'b0, 22'h200000, 3'd4, 32'h0, r);
    chk("R3 disabled read returns zero", r, 32'h0);
    chk("R3 disabled issues nothing", wr_cnt + rd_cnt, w0);
  endtask

  task automatic t_full_write_decode();
    logic [31:0] r;
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    access(1'b1, 22'h000000, 3'd4, 32'h472B_0080, r);
    access(1'b1, 22'h200000, 3'd4, 32'h1122_3344, r);
    chk("R5 single write", wr_cnt - w0, 1);
    chk("R5 no read", rd_cnt - r0, 0);
    chk("R5 swapped data", l_wd, 32'h4433_2211);
    chk("R4 type0", {31'b0, l_type1}, 32'h0);
    chk("R4 device", {27'b0, l_dev}, 32'd5);
    chk("R4 function", {29'b0, l_func}, 32'd3);
    chk("R4 register low bits cleared", {24'b0, l_reg}, 32'h44);
    chk("R11 size4", {29'b0, l_size}, 32'd4);
    access(1'b1, 22'h000000, 3'd4, 32'h472B_0280, r);
    access(1'b0, 22'h200000, 3'd4, 32'h0, r);
    chk("R8 dword read swapped", r, 32'h1122_3344);
    chk("R4 type1", {31'b0, l_type1}, 32'h1);
    chk("R4 bus", {24'b0, l_bus}, 32'd2);
  endtask

  task automatic t_narrow_write();
    logic [31:0] r;
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    access(1'b1, 22'h200002, 3'd1, 32'h0000_00AB, r);
    chk("R6 byte write read count", rd_cnt - r0, 1);
    chk("R6 byte write write count", wr_cnt - w0, 1);
    chk("R6 byte merged", l_wd, 32'h44AB_2211);
    chk("R11 size1", {29'b0, l_size}, 32'd1);
    chk("R11 offset2", {30'b0, l_off}, 32'd2);
    access(1'b1, 22'h200000, 3'd2, 32'h0000_C0DE, r);
    chk("R6 half merged", l_wd, 32'h44AB_DEC0);
  endtask

  task automatic t_narrow_read();
    logic [31:0] r;
    access(1'b0, 22'h200001, 3'd1, 32'h0, r);
    chk("R8 byte read", r, 32'h0000_00DE);
    access(1'b0, 22'h200002, 3'd2, 32'h0, r);
    chk("R8 half read", r, 32'h0000_AB44);
  endtask

  task automatic t_absent();
    logic [31:0] r;
    int w0, r0;
    access(1'b1, 22'h000000, 3'd4, 32'h44F8_0180, r);
    access(1'b0, 22'h200000, 3'd4, 32'h0, r);
    chk("R9 absent read all ones", r, 32'hFFFF_FFFF);
    w0 = wr_cnt; r0 = rd_cnt;
    access(1'b1, 22'h200001, 3'd1, 32'h0000_0077, r);
    chk("R7 absent narrow read issued", rd_cnt - r0, 1);
    chk("R7 absent no write-back", wr_cnt - w0, 0);
  endtask

  task automatic t_busy_overlap();
    logic [31:0] r;
    access(1'b1, 22'h000000, 3'd4, 32'h472B_0080, r);
    ready_lag = 3; rsp_lag = 2;
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0; host_addr = 22'h200000; host_size = 3'd4;
    @(negedge clk);
    chk("R10 busy during transfer", {31'b0, host_busy}, 32'h1);
    host_wr = 1'b1; host_addr = 22'h000000; host_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_done) @(negedge clk);
    chk("R10 stalled read data", host_rdata, 32'hC0DE_AB44);
    ready_lag = 0; rsp_lag = 0;
    access(1'b0, 22'h000000, 3'd4, 32'h0, r);
    chk("R10 address word untouched while busy", r, 32'h472B_0080);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) store[i] = '0;
    for (int c = 0; c < 50000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addr_word();
    t_disabled();
    t_full_write_decode();
    t_narrow_write();
    t_narrow_read();
    t_absent();
    t_busy_overlap();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule